// File: doc/BRIEF.md
# Multi-UART Window Decoder with Interrupt Merge

This block sits between a simple host register bus and up to four UART cores. It decodes every access inside a 4096-byte memory window. It steers each hit to the 8-byte register window of one UART, and it passes the offset inside that window through to the core. The windows do not have to sit back to back. A 12-bit slot mask sets where they go: each set bit claims one 8-byte slot, and ports take the set bits in ascending order. This gives sparse layouts such as slots 0, 2 and 7, or slots 0, 1, 2 and 7.

The block captures the slot mask while reset is held and keeps the resulting port-to-slot map in registers after that. Accesses that fall into no claimed slot still complete in one cycle. A read of such an address returns zero, and a write to it is dropped. The block also stores the latest interrupt level of each port that owns a slot, and it merges these levels into one level-sensitive interrupt.

Top module: `uart_window_decoder`

## Requirements
- R1: While a read or write strobe hits a port, `port_addr` equals the host address modulo 8, and `port_wdata` carries the host write data.
- R2: Bit i of the slot mask claims bytes 8*i to 8*i+7. Port k is given the k-th lowest set bit. An access inside that slot raises only `port_sel[k]`.
- R3: An access to an address that no port owns raises no `port_sel` bit. A read of that address returns 0, and a write to it changes no port register.
- R4: Set mask bits beyond the first NPORTS are ignored, and addresses in those slots miss. When the mask is all zero, no port is ever selected.
- R5: The port-to-slot map is loaded from `slot_mask` on every clock edge while `rst_n` is low. Changes of `slot_mask` after reset have no effect on decoding.
- R6: `irq_out` is high one cycle after any port that owns a slot has its interrupt input high. It goes low one cycle after all such inputs are low.
- R7: The interrupt input of a port that owns no slot never raises `irq_out`.
- R8: `host_ready` is high for exactly the cycle after each cycle with a read or write strobe. On a read, `host_rdata` holds the selected port's data in that same cycle.
- R9: After reset, `host_ready`, `irq_out` and all `port_sel` bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; the slot map loads while it is low |
| slot_mask | input | 12 | Slot mask, one bit per 8-byte slot |
| host_addr | input | 12 | Byte address inside the 4 KiB window |
| host_rd | input | 1 | Read strobe, one cycle per access |
| host_wr | input | 1 | Write strobe, one cycle per access |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data, valid when host_ready is high |
| host_ready | output | 1 | Access completion, one cycle after the strobe |
| port_sel | output | 4 | One-hot select of the addressed UART |
| port_addr | output | 3 | Register offset inside the UART window |
| port_wdata | output | 8 | Write data for the UART |
| port_wr | output | 1 | Write strobe for the UART |
| port_rd | output | 1 | Read strobe for the UART |
| port_rdata | input | 32 | Read data from the UARTs, 8 bits per port, port 0 in the low byte |
| port_irq | input | 4 | Interrupt level of each UART |
| irq_out | output | 1 | Merged interrupt |

## Verification
The bench builds the block at its default size: four ports, a 12-bit mask and an 8-bit data path. This keeps every layout within reach by changing only the mask sampled at reset. The dense layout with slots 0, 1, 2 and 7 is tested, and so are the sparse three-port layout, a mask with more set bits than ports, and an empty mask. Because four ports exist but a mask may claim fewer slots, the case of a port with no slot, whose interrupt and window must stay inert, can be observed at the pins.

// File: rtl/uart_window_decoder.sv
module uart_window_decoder #(
  parameter int NPORTS = 4,
  parameter int MASK_W = 12,
  parameter int ADDR_W = 12,
  parameter int DATA_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [MASK_W-1:0]        slot_mask,
  input  logic [ADDR_W-1:0]        host_addr,
  input  logic                     host_rd,
  input  logic                     host_wr,
  input  logic [DATA_W-1:0]        host_wdata,
  output logic [DATA_W-1:0]        host_rdata,
  output logic                     host_ready,
  output logic [NPORTS-1:0]        port_sel,
  output logic [2:0]               port_addr,
  output logic [DATA_W-1:0]        port_wdata,
  output logic                     port_wr,
  output logic                     port_rd,
  input  logic [NPORTS*DATA_W-1:0] port_rdata,
  input  logic [NPORTS-1:0]        port_irq,
  output logic                     irq_out
);
  localparam int SLOT_AW = 3;
  localparam int IDX_W   = $clog2(MASK_W);
  localparam int TAG_W   = ADDR_W - SLOT_AW;

  logic [NPORTS-1:0][IDX_W-1:0] map_nxt, map_q;
  logic [NPORTS-1:0]            en_nxt, en_q;
  logic [NPORTS-1:0]            hit, irq_lvl;
  logic [DATA_W-1:0]            rd_mux;
  logic                         acc;

  always_comb begin
    int cnt;
    cnt = 0;
    map_nxt = '0;
    en_nxt  = '0;
    for (int i = 0; i < MASK_W; i++) begin
      if (slot_mask[i] && cnt < NPORTS) begin
        map_nxt[cnt] = IDX_W'(i);
        en_nxt[cnt]  = 1'b1;
        cnt = cnt + 1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      map_q <= map_nxt;
      en_q  <= en_nxt;
    end
  end

  assign acc = host_rd | host_wr;

  for (genvar p = 0; p < NPORTS; p++) begin : g_dec
    assign hit[p] = en_q[p] && (host_addr[ADDR_W-1:SLOT_AW] == TAG_W'(map_q[p]));
  end

  assign port_sel   = hit & {NPORTS{acc}};
  assign port_addr  = host_addr[SLOT_AW-1:0];
  assign port_wdata = host_wdata;
  assign port_wr    = host_wr & (|hit);
  assign port_rd    = host_rd & (|hit);

  always_comb begin
    rd_mux = '0;
    for (int p = 0; p < NPORTS; p++)
      if (hit[p]) rd_mux = rd_mux | port_rdata[p*DATA_W +: DATA_W];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      host_ready <= 1'b0;
      host_rdata <= '0;
      irq_lvl    <= '0;
    end else begin
      host_ready <= acc;
      if (host_rd) host_rdata <= rd_mux;
      irq_lvl <= port_irq & en_q;
    end
  end

  assign irq_out = |irq_lvl;
endmodule

// File: rtl/uart_window_decoder_chk.sv
module uart_window_decoder_chk #(
  parameter int NPORTS = 4,
  parameter int DATA_W = 8,
  parameter int MAP_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              host_rd,
  input logic              host_wr,
  input logic              host_ready,
  input logic [DATA_W-1:0] host_rdata,
  input logic [NPORTS-1:0] port_sel,
  input logic [NPORTS-1:0] port_irq,
  input logic [NPORTS-1:0] en_q,
  input logic [MAP_W-1:0]  map_q,
  input logic              irq_out
);
  a_r8_ready_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd || host_wr) |=> host_ready);
  a_r8_no_spurious_ready: assert property (@(posedge clk) disable iff (!rst_n)
    !(host_rd || host_wr) |=> !host_ready);
  a_r2_single_select: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(port_sel));
  a_r3_miss_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && port_sel == '0) |=> host_rdata == '0);
  a_r5_map_held: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> ($stable(map_q) && $stable(en_q)));
  a_r6_any_raises: assert property (@(posedge clk) disable iff (!rst_n)
    (|(port_irq & en_q)) |=> irq_out);
  a_r7_inert_low: assert property (@(posedge clk) disable iff (!rst_n)
    ((port_irq & en_q) == '0) |=> !irq_out);
endmodule

bind uart_window_decoder uart_window_decoder_chk #(
  .NPORTS(NPORTS), .DATA_W(DATA_W), .MAP_W(NPORTS*$clog2(MASK_W))
) u_chk (
  .clk(clk), .rst_n(rst_n), .host_rd(host_rd), .host_wr(host_wr),
  .host_ready(host_ready), .host_rdata(host_rdata), .port_sel(port_sel),
  .port_irq(port_irq), .en_q(en_q), .map_q(map_q), .irq_out(irq_out)
);

// File: tb/sim_uart_window_decoder.sv
`timescale 1ns/1ps
module sim_uart_window_decoder;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [11:0] slot_mask = 12'h087;
  logic [11:0] host_addr = 0;
  logic        host_rd = 0, host_wr = 0;
  logic [7:0]  host_wdata = 0;
  logic [7:0]  host_rdata;
  logic        host_ready;
  logic [3:0]  port_sel;
  logic [2:0]  port_addr;
  logic [7:0]  port_wdata;
  logic        port_wr, port_rd;
  logic [31:0] port_rdata;
  logic [3:0]  port_irq = 0;
  logic        irq_out;
  int total = 0, bad = 0;
  logic [7:0] stub [4][8];

  always #5 clk = ~clk;

  uart_window_decoder u0 (.*);

  always @(posedge clk)
    for (int p = 0; p < 4; p++)
      if (port_sel[p] && port_wr) stub[p][port_addr] <= port_wdata;

  always_comb
    for (int p = 0; p < 4; p++) port_rdata[p*8 +: 8] = stub[p][port_addr];

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset(logic [11:0] m);
    @(negedge clk);
    rst_n = 0; slot_mask = m;
    repeat (3) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic wr(logic [11:0] a, logic [7:0] d, logic [3:0] sel_exp);
    @(negedge clk);
    host_addr = a; host_wdata = d; host_wr = 1;
    #1;
    check("R2 select", port_sel, sel_exp);
    check("R1 local address", port_addr, a % 8);
    @(negedge clk);
    host_wr = 0;
    check("R8 write ready", host_ready, 1);
  endtask

  task automatic rd(logic [11:0] a, logic [7:0] exp, string req);
    @(negedge clk);
    host_addr = a; host_rd = 1;
    @(negedge clk);
    host_rd = 0;
    check("R8 read ready", host_ready, 1);
    check(req, host_rdata, exp);
    @(negedge clk);
    check("R8 ready one cycle", host_ready, 0);
  endtask

  task automatic irq_step(logic [3:0] v, logic exp, string req);
    @(negedge clk);
    port_irq = v;
    @(negedge clk);
    check(req, irq_out, exp);
  endtask

  task automatic t_reset_state;
    do_reset(12'h087);
    #1;
    check("R9 ready after reset", host_ready, 0);
    check("R9 irq after reset", irq_out, 0);
    check("R9 select after reset", port_sel, 0);
  endtask

  task automatic t_dense_layout;
    wr(12'd0 + 1, 8'hA0, 4'b0001);
    wr(12'd8 + 2, 8'hA1, 4'b0010);
    wr(12'd16 + 5, 8'hA2, 4'b0100);
    wr(12'd56 + 7, 8'hA3, 4'b1000);
    rd(12'd1, 8'hA0, "R2 port0 slot0");
    rd(12'd10, 8'hA1, "R2 port1 slot1");
    rd(12'd21, 8'hA2, "R1 port2 offset5");
    rd(12'd63, 8'hA3, "R2 port3 slot7");
  endtask

  task automatic t_miss;
    rd(12'd24, 8'h00, "R3 miss read slot3");
    wr(12'd24 + 1, 8'hFF, 4'b0000);
    wr(12'hFF2, 8'hEE, 4'b0000);
    rd(12'd1, 8'hA0, "R3 miss write kept port0");
    rd(12'd10, 8'hA1, "R3 miss write kept port1");
    rd(12'd21, 8'hA2, "R3 miss write kept port2");
    rd(12'd63, 8'hA3, "R3 miss write kept port3");
  endtask

  task automatic t_mask_after_reset;
    @(negedge clk);
    slot_mask = 12'h0F0;
    rd(12'd63, 8'hA3, "R5 map held after mask change");
    rd(12'd1, 8'hA0, "R5 slot0 still port0");
  endtask

  task automatic t_irq_merge;
    irq_step(4'b0001, 1, "R6 port0 raises");
    irq_step(4'b1001, 1, "R6 two ports high");
    irq_step(4'b1000, 1, "R6 one remains high");
    irq_step(4'b0000, 0, "R6 all low clears");
    irq_step(4'b0100, 1, "R6 port2 raises");
    irq_step(4'b0000, 0, "R6 clears again");
  endtask

  task automatic t_sparse_three;
    do_reset(12'h085);
    wr(12'd16 + 3, 8'hB1, 4'b0010);
    wr(12'd56, 8'hB2, 4'b0100);
    rd(12'd19, 8'hB1, "R2 sparse port1 slot2");
    rd(12'd56, 8'hB2, "R2 sparse port2 slot7");
    rd(12'd8, 8'h00, "R3 sparse slot1 misses");
    irq_step(4'b1000, 0, "R7 port without slot ignored");
    irq_step(4'b0000, 0, "R7 quiet");
  endtask

  task automatic t_extra_bits;
    do_reset(12'h0F3);
    wr(12'd40 + 4, 8'hC3, 4'b1000);
    rd(12'd44, 8'hC3, "R4 port3 at slot5");
    wr(12'd48, 8'hCC, 4'b0000);
    rd(12'd48, 8'h00, "R4 slot6 beyond ports misses");
    rd(12'd60, 8'h00, "R4 slot7 beyond ports misses");
  endtask

  task automatic t_empty_mask;
    do_reset(12'h000);
    wr(12'd0, 8'hDD, 4'b0000);
    rd(12'd0, 8'h00, "R4 empty mask read");
    irq_step(4'b1111, 0, "R7 empty mask irq ignored");
    irq_step(4'b0000, 0, "R7 empty mask quiet");
  endtask

  initial begin
    #2_000_000;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total + 1, bad);
    $finish;
  end

  initial begin
    for (int p = 0; p < 4; p++)
      for (int a = 0; a < 8; a++) stub[p][a] = 8'h00;
    t_reset_state();
    t_dense_layout();
    t_miss();
    t_mask_after_reset();
    t_irq_merge();
    t_sparse_three();
    t_extra_bits();
    t_empty_mask();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule